// File: doc/BRIEF.md
# Horizontal Accumulating Video Prescaler

This block reduces the horizontal sample rate of an 8-bit video stream. It adds a programmable number of consecutive input samples into one output sample and then divides the sum by a power of two. Each window holds the programmed length plus one sample. Windows follow one another without overlap. A mode input selects the weighting. With flat weighting, every sample in the window counts once. With end-tapered weighting, the interior samples count twice and the two end samples count once.

A line-start marker realigns the window to the start of a new video line and discards any part of a window left over from the previous line. The scaled result is rounded, clipped to the 8-bit range and presented with a one-cycle valid pulse. Configuration inputs are expected to stay constant for the whole of a line.

Top module: `hacc_prescaler`

## Requirements
- R1: With length setting `accLen` = N (0 to 63), each output covers exactly N+1 accepted samples. Exactly one `outValid` pulse is issued per completed window, in the cycle after the clock edge that accepts the window's last sample.
- R2: When `weightMode` = 0, every sample in the window has weight 1 (N=4 gives 1,1,1,1,1).
- R3: When `weightMode` = 1, the first and last samples of the window have weight 1 and all samples between them have weight 2 (N=4 gives 1,2,2,2,1). With N=0 the single sample has weight 1, and with N=1 both samples have weight 1.
- R4: Gain code `gainCode` = k (0 to 7) divides the weighted sum by 2^k, so code 7 gives 1/128. Rounding is half-up: 2^(k-1) is added before the shift when k is greater than 0. The mode bit does not alter this step.
- R5: A scaled result above 255 is output as 255.
- R6: Windows do not overlap. A line of L samples produces floor(L/(N+1)) outputs.
- R7: `lineStart` high in any cycle restarts the window count and drops the partial sum. If `pixValid` is also high in that cycle, that sample becomes the first sample of the new window.
- R8: The full-scale case (N=63, `weightMode`=1, all samples 255) produces the exact rounded result with no wraparound. For example, gain code 7 gives 251.
- R9: After reset, `outValid` = 0 and `pixOut` = 0. `pixOut` holds its value in every cycle where `outValid` is low.
- R10: `pixIn` is ignored in cycles where `pixValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixIn | input | 8 | Input sample |
| pixValid | input | 1 | Input sample strobe |
| lineStart | input | 1 | Start-of-line marker |
| accLen | input | 6 | Window length minus one |
| weightMode | input | 1 | 0 flat, 1 interior weight two |
| gainCode | input | 3 | Post-accumulation shift amount |
| pixOut | output | 8 | Decimated sample |
| outValid | output | 1 | Output strobe |

## Verification
The window-count and pass-through properties assume that `accLen`, `weightMode` and `gainCode` do not change in the middle of a line. A mid-line change would make the window boundary ambiguous. The stimulus therefore changes configuration only between lines, after a few idle cycles and before the next `lineStart`. It also drives `pixIn` with unrelated data during cycles where `pixValid` is low. This gives the checks on ignored input a real disturbance to observe.

// File: rtl/hacc_pkg.sv
package hacc_pkg;
  typedef struct packed {
    logic accept;   // a sample is taken this cycle
    logic first;    // sample opens a new window
    logic heavy;    // sample sits inside the window (weight two)
    logic last;     // sample closes the window
  } hacc_strobe_t;
endpackage

// File: rtl/hacc_ctrl.sv
module hacc_ctrl
  import hacc_pkg::*;
#(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pixValid,
  input  logic             lineStart,
  input  logic [LEN_W-1:0] accLen,
  input  logic             weightMode,
  output hacc_strobe_t     strobe
);
  logic [LEN_W-1:0] winPos;
  logic [LEN_W-1:0] curPos;
  logic             atEnd;

  always_comb begin
    curPos = lineStart ? '0 : winPos;
    atEnd  = (curPos == accLen);
    strobe.accept = pixValid;
    strobe.first  = pixValid && (curPos == '0);
    strobe.last   = pixValid && atEnd;
    strobe.heavy  = pixValid && weightMode && (curPos != '0) && !atEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winPos <= '0;
    end else if (pixValid) begin
      winPos <= atEnd ? '0 : curPos + 1'b1;
    end else if (lineStart) begin
      winPos <= '0;
    end
  end
endmodule

// File: rtl/hacc_dpath.sv
module hacc_dpath
  import hacc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 6,
  parameter int GAIN_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  hacc_strobe_t      strobe,
  input  logic [DATA_W-1:0] pixIn,
  input  logic [GAIN_W-1:0] gainCode,
  output logic [DATA_W-1:0] pixOut,
  output logic              outValid
);
  localparam int ACC_W = DATA_W + LEN_W + 1;
  localparam int RND_W = ACC_W + 1;
  localparam logic [RND_W-1:0] MAX_OUT = RND_W'((1 << DATA_W) - 1);

  logic [ACC_W-1:0] accSum;
  logic [ACC_W-1:0] weighted;
  logic [ACC_W-1:0] sumNext;
  logic [RND_W-1:0] halfStep;
  logic [RND_W-1:0] rounded;
  logic [RND_W-1:0] scaled;
  logic [DATA_W-1:0] clipped;

  always_comb begin
    weighted = strobe.heavy ? (ACC_W'(pixIn) << 1) : ACC_W'(pixIn);
    sumNext  = (strobe.first ? '0 : accSum) + weighted;
    halfStep = (RND_W'(1) << gainCode) >> 1;
    rounded  = RND_W'(sumNext) + halfStep;
    scaled   = rounded >> gainCode;
    clipped  = (scaled > MAX_OUT) ? MAX_OUT[DATA_W-1:0] : scaled[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accSum   <= '0;
      pixOut   <= '0;
      outValid <= 1'b0;
    end else begin
      if (strobe.accept) accSum <= sumNext;
      outValid <= strobe.accept && strobe.last;
      if (strobe.accept && strobe.last) pixOut <= clipped;
    end
  end
endmodule

// File: rtl/hacc_prescaler.sv
module hacc_prescaler
  import hacc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 6,
  parameter int GAIN_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] pixIn,
  input  logic              pixValid,
  input  logic              lineStart,
  input  logic [LEN_W-1:0]  accLen,
  input  logic              weightMode,
  input  logic [GAIN_W-1:0] gainCode,
  output logic [DATA_W-1:0] pixOut,
  output logic              outValid
);
  hacc_strobe_t strobe;

  hacc_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .lineStart(lineStart),
    .accLen(accLen), .weightMode(weightMode), .strobe(strobe)
  );

  hacc_dpath #(.DATA_W(DATA_W), .LEN_W(LEN_W), .GAIN_W(GAIN_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pixIn(pixIn),
    .gainCode(gainCode), .pixOut(pixOut), .outValid(outValid)
  );
endmodule

// File: rtl/hacc_prescaler_chk.sv
module hacc_prescaler_chk #(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 6,
  parameter int GAIN_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] pixIn,
  input logic              pixValid,
  input logic              lineStart,
  input logic [LEN_W-1:0]  accLen,
  input logic              weightMode,
  input logic [GAIN_W-1:0] gainCode,
  input logic [DATA_W-1:0] pixOut,
  input logic              outValid
);
  logic [LEN_W:0] runLen;
  logic [LEN_W:0] runNow;
  logic           winDone;

  always_comb begin
    runNow  = (lineStart ? '0 : runLen) + 1'b1;
    winDone = pixValid && (runNow == ({1'b0, accLen} + 1'b1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) runLen <= '0;
    else if (pixValid) runLen <= winDone ? '0 : runNow;
    else if (lineStart) runLen <= '0;
  end

  p_window_emits_r1: assert property (@(posedge clk) disable iff (!rstN)
    winDone |=> outValid);

  p_emit_needs_window_r1: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(winDone));

  p_idle_input_no_output_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(pixValid) |-> !outValid);

  p_single_unit_pass_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(accLen) == '0 && $past(gainCode) == '0) |-> pixOut == $past(pixIn));

  p_hold_output_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pixOut) |-> outValid);
endmodule

bind hacc_prescaler hacc_prescaler_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W), .GAIN_W(GAIN_W)) u_chk (
  .clk(clk), .rstN(rstN), .pixIn(pixIn), .pixValid(pixValid), .lineStart(lineStart),
  .accLen(accLen), .weightMode(weightMode), .gainCode(gainCode),
  .pixOut(pixOut), .outValid(outValid)
);

// File: tb/tb_hacc_prescaler.sv
module tb_hacc_prescaler;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] pixIn = '0;
  logic       pixValid = 1'b0;
  logic       lineStart = 1'b0;
  logic [5:0] accLen = '0;
  logic       weightMode = 1'b0;
  logic [2:0] gainCode = '0;
  logic [7:0] pixOut;
  logic       outValid;

  int checks = 0;
  int fails = 0;
  int outCount = 0;
  bit monOn = 0;
  bit done = 0;
  logic [7:0] lastOut = '0;
  int    expQ[$];
  string tagQ[$];
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  hacc_prescaler dut (
    .clk(clk), .rstN(rstN), .pixIn(pixIn), .pixValid(pixValid), .lineStart(lineStart),
    .accLen(accLen), .weightMode(weightMode), .gainCode(gainCode),
    .pixOut(pixOut), .outValid(outValid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] nextRand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[7:0];
  endfunction

  // monitor: compares against the expected queue every cycle
  initial begin
    forever begin
      @(negedge clk);
      if (monOn) begin
        if (outValid) begin
          outCount++;
          if (expQ.size() == 0) chk(1'b0, "R1 unexpected output", 1, 0);
          else begin
            int e;
            string t;
            e = expQ.pop_front();
            t = tagQ.pop_front();
            chk(pixOut == e[7:0], t, int'(pixOut), e);
          end
          lastOut = pixOut;
        end else begin
          chk(pixOut == lastOut, "R9 hold", int'(pixOut), int'(lastOut));
        end
      end
    end
  end

  // one line of samples with the current configuration
  task automatic runLine(input int len, input int pat, input bit preMark);
    int idx = 0;
    int sum = 0;
    int sent = 0;
    int n = int'(accLen);
    int startCount;
    startCount = outCount;
    if (preMark) begin
      @(negedge clk);
      lineStart = 1'b1; pixValid = 1'b0; pixIn = nextRand();
    end
    for (int k = 0; sent < len; k++) begin
      @(negedge clk);
      if (k % 5 == 3) begin
        // R10: garbage while invalid
        pixValid = 1'b0; lineStart = 1'b0; pixIn = nextRand();
      end else begin
        logic [7:0] d;
        int w;
        case (pat)
          0: d = 8'd255;
          1: d = nextRand();
          default: d = 8'(sent * 7 + 3);
        endcase
        pixValid = 1'b1; pixIn = d; lineStart = (sent == 0);
        if (sent == 0) begin idx = 0; sum = 0; end
        w = (weightMode && idx != 0 && idx != n) ? 2 : 1;
        sum += w * int'(d);
        if (idx == n) begin
          int g = int'(gainCode);
          int r = (sum + ((1 << g) >> 1)) >> g;
          string t;
          if (n == 63) t = "R8 full scale";
          else if (r > 255) t = "R5 clip";
          else if (g != 0) t = "R4 gain";
          else if (weightMode) t = "R3 tapered";
          else t = "R2 flat";
          expQ.push_back(r > 255 ? 255 : r);
          tagQ.push_back(t);
          idx = 0; sum = 0;
        end else idx++;
        sent++;
      end
    end
    @(negedge clk);
    pixValid = 1'b0; lineStart = 1'b0; pixIn = nextRand();
    repeat (2) @(negedge clk);
    chk(expQ.size() == 0, "R1 missing output", expQ.size(), 0);
    chk(outCount - startCount == len / (n + 1), "R6 window count",
        outCount - startCount, len / (n + 1));
  endtask

  initial begin
    int lens[7] = '{0, 1, 2, 3, 4, 7, 63};
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R9 reset valid", int'(outValid), 0);
    chk(pixOut == 8'd0, "R9 reset data", int'(pixOut), 0);
    @(negedge clk);
    rstN = 1'b1;
    monOn = 1;
    @(negedge clk);
    foreach (lens[i]) begin
      for (int m = 0; m < 2; m++) begin
        for (int g = 0; g < 8; g++) begin
          for (int p = 0; p < 3; p++) begin
            accLen = 6'(lens[i]); weightMode = m[0]; gainCode = 3'(g);
            // R7: each line ends with a partial window that must be dropped
            runLine(2 * (lens[i] + 1) + lens[i], p, (p == 1));
          end
        end
      end
    end
    // R7 and R3: restart mid-window, N=4 tapered, unity gain
    accLen = 6'd4; weightMode = 1'b1; gainCode = 3'd0;
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      pixValid = 1'b1; lineStart = (k == 0); pixIn = 8'd200;
      @(negedge clk);
    end
    pixValid = 1'b1; lineStart = 1'b1; pixIn = 8'd10;
    expQ.push_back(10 + 2 * 20 + 2 * 30 + 2 * 40 + 50); tagQ.push_back("R7 restart");
    @(negedge clk);
    for (int k = 1; k < 5; k++) begin
      lineStart = 1'b0; pixIn = 8'(10 * (k + 1));
      @(negedge clk);
    end
    pixValid = 1'b0;
    repeat (2) @(negedge clk);
    chk(expQ.size() == 0, "R7 restart output", expQ.size(), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R1 watchdog expired", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule